// File: doc/BRIEF.md
# Fixed-Point Boost Converter Plant Model

This block is a discrete-time model of a boost DC-DC converter for real-time hardware-in-the-loop emulation. It holds two signed fixed-point states, the inductor current and the output voltage. Each time a step strobe is seen on a rising clock edge, it advances both states by one forward-Euler step of length dt. The switch gate input, the input voltage and the load current are sampled on that edge. The two step gains, dt/L and dt/C, are unsigned fixed-point parameters.

The update has three modes. With the gate high, the switch conducts. With the gate low and a positive inductor current, the diode conducts (continuous conduction). With the gate low and a current that is not positive, the converter is in discontinuous conduction. The states keep full resolution. Each state's update, however, reads only a truncated, reduced-precision copy of the other state. Both copies are also brought out as ports. A synchronous reset loads the states from two initial-value inputs. Between strobes the states hold their values.

Top module: `boost_plant`

## Requirements
- R1: While `rst` is high on a rising edge, `vOut` takes `initVout` and `iInd` takes `initIl`, whatever `stepEn` is. Reset takes precedence over a step.
- R2: On an edge with `rst` low and `stepEn` low, both states keep their values, whatever `gate`, `vIn` and `iLoad` are.
- R3: Step with `gate`=1 (switch on). `iInd` += floor(DTL·vIn / 2^10) and `vOut` += floor(DTC·(−iLoad) / 2^10). Here DTL and DTC are the gain codes, with 24 fractional bits. vIn has 3 fractional bits and iLoad has 10, so with the default widths both shifts are 10.
- R4: Step with `gate`=0 and `iInd`>0 (continuous conduction). `iInd` += floor(DTL·(vIn − vOutFb) / 2^10) and `vOut` += floor(DTC·(iIndFb − iLoad) / 2^10). Both use the feedback copies as they stood before the edge.
- R5: In continuous conduction, a result for `iInd` that would be negative is replaced by exactly 0.
- R6: Step with `gate`=0 and `iInd`≤0 (discontinuous conduction). `iInd` becomes 0 and `vOut` += floor(DTC·(−iLoad) / 2^10).
- R7: `vOutFb` equals `vOut` shifted arithmetically right by 21 (Q11.3 from Q11.24). `iIndFb` equals `iInd` shifted arithmetically right by 7 (Q8.10 from Q8.17). In both cases the result rounds toward minus infinity.
- R8: When a step result leaves the state format, the state saturates. For `iInd` the limits are 2^25−1 and −2^25. For `vOut` they are 2^35−1 and −2^35.
- R9: A strobe held high for k consecutive edges performs k chained updates. Each update starts from the result of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the initial values |
| stepEn | input | 1 | One model step per edge while high |
| gate | input | 1 | Switch gate: 1 = conducting |
| vIn | input | 13 | Input voltage, signed Q9.3 |
| iLoad | input | 13 | Load current, signed Q2.10 |
| initVout | input | 36 | Initial output voltage, signed Q11.24 |
| initIl | input | 26 | Initial inductor current, signed Q8.17 |
| vOut | output | 36 | Output voltage state, signed Q11.24 |
| iInd | output | 26 | Inductor current state, signed Q8.17 |
| vOutFb | output | 15 | Reduced output voltage copy, signed Q11.3 |
| iIndFb | output | 19 | Reduced inductor current copy, signed Q8.10 |

## Verification
The bench uses the default parameters. The state formats are Q11.24 and Q8.17, the feedback copies keep 3 and 10 fractional bits, and the gains correspond to dt = 1 µs with L = 1 mH and C = 100 µF. With gains this small, a 200 V input moves the current by about 0.2 A per step. The clamp is reached by driving a zero input voltage against a 400 V output while a small current is flowing. Because the initial values are ports, the bench can place either state a few LSBs from its format limit, which puts saturation within one step. A negative initial voltage makes the truncated feedback copy round toward minus infinity.

// File: rtl/boost_pkg.sv
package boost_pkg;

  typedef enum logic [1:0] {
    MODE_ON  = 2'd0,
    MODE_CCM = 2'd1,
    MODE_DCM = 2'd2
  } step_mode_e;

  typedef struct packed {
    logic       loadInit;
    logic       update;
    step_mode_e mode;
  } step_ctrl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boost_ctrl.sv
module boost_ctrl
  import boost_pkg::*;
(
  input  logic       rst,
  input  logic       stepEn,
  input  logic       gate,
  input  logic       ilPositive,
  output step_ctrl_t ctl
);

  always_comb begin
    ctl.loadInit = rst;
    ctl.update   = !rst && stepEn;
    if (gate)            ctl.mode = MODE_ON;
    else if (ilPositive) ctl.mode = MODE_CCM;
    else                 ctl.mode = MODE_DCM;
  end

endmodule

// File: rtl/boost_dpath.sv
module boost_dpath
  import boost_pkg::*;
#(
  parameter int V_INT    = 11,
  parameter int V_FRAC   = 24,
  parameter int I_INT    = 8,
  parameter int I_FRAC   = 17,
  parameter int VG_INT   = 9,
  parameter int VG_FRAC  = 3,
  parameter int IR_INT   = 2,
  parameter int IR_FRAC  = 10,
  parameter int VFB_FRAC = 3,
  parameter int IFB_FRAC = 10,
  parameter int K_W      = 20,
  parameter int K_FRAC   = 24,
  parameter int DTL_CODE = 16777,
  parameter int DTC_CODE = 167772,
  localparam int VW   = 1 + V_INT + V_FRAC,
  localparam int ILW  = 1 + I_INT + I_FRAC,
  localparam int VGW  = 1 + VG_INT + VG_FRAC,
  localparam int IRW  = 1 + IR_INT + IR_FRAC,
  localparam int VFBW = 1 + V_INT + VFB_FRAC,
  localparam int IFBW = 1 + I_INT + IFB_FRAC
) (
  input  logic            clk,
  input  step_ctrl_t      ctl,
  input  logic [VGW-1:0]  vIn,
  input  logic [IRW-1:0]  iLoad,
  input  logic [VW-1:0]   initVout,
  input  logic [ILW-1:0]  initIl,
  output logic [VW-1:0]   vOut,
  output logic [ILW-1:0]  iInd,
  output logic [VFBW-1:0] vOutFb,
  output logic [IFBW-1:0] iIndFb,
  output logic            ilPositive
);

  // current path: operand (input voltage minus voltage feedback)
  localparam int DIF = maxOf(VG_FRAC, VFB_FRAC);
  localparam int DII = maxOf(VG_INT, V_INT) + 1;
  localparam int DIW = 1 + DII + DIF;
  localparam int PIW = DIW + K_W + 1;
  localparam int SHI = DIF + K_FRAC - I_FRAC;
  localparam int QIW = PIW - SHI;
  localparam int SIW = maxOf(ILW, QIW) + 1;

  // voltage path: operand (current feedback minus load current)
  localparam int DVF = maxOf(IR_FRAC, IFB_FRAC);
  localparam int DVI = maxOf(IR_INT, I_INT) + 1;
  localparam int DVW = 1 + DVI + DVF;
  localparam int PVW = DVW + K_W + 1;
  localparam int SHV = DVF + K_FRAC - V_FRAC;
  localparam int QVW = PVW - SHV;
  localparam int SVW = maxOf(VW, QVW) + 1;

  localparam logic [K_W-1:0] DTL_K = K_W'(DTL_CODE);
  localparam logic [K_W-1:0] DTC_K = K_W'(DTC_CODE);

  localparam logic signed [SIW-1:0] I_HI = {{(SIW-ILW+1){1'b0}}, {(ILW-1){1'b1}}};
  localparam logic signed [SIW-1:0] I_LO = {{(SIW-ILW+1){1'b1}}, {(ILW-1){1'b0}}};
  localparam logic signed [SVW-1:0] V_HI = {{(SVW-VW+1){1'b0}}, {(VW-1){1'b1}}};
  localparam logic signed [SVW-1:0] V_LO = {{(SVW-VW+1){1'b1}}, {(VW-1){1'b0}}};

  logic signed [VW-1:0]  vReg;
  logic signed [ILW-1:0] iReg;

  // reduced-precision copies: drop low fractional bits (floor)
  generate
    if (VFB_FRAC == V_FRAC) begin : g_vfb_full
      assign vOutFb = vReg;
    end else begin : g_vfb_trunc
      assign vOutFb = vReg[VW-1 : V_FRAC-VFB_FRAC];
    end
    if (IFB_FRAC == I_FRAC) begin : g_ifb_full
      assign iIndFb = iReg;
    end else begin : g_ifb_trunc
      assign iIndFb = iReg[ILW-1 : I_FRAC-IFB_FRAC];
    end
  endgenerate

  // aligned operands
  logic signed [DIW-1:0] vgAl, vfbAl, opI;
  logic signed [DVW-1:0] irAl, ifbAl, opV;

  assign vgAl  = DIW'($signed(vIn))    <<< (DIF - VG_FRAC);
  assign vfbAl = DIW'($signed(vOutFb)) <<< (DIF - VFB_FRAC);
  assign irAl  = DVW'($signed(iLoad))  <<< (DVF - IR_FRAC);
  assign ifbAl = DVW'($signed(iIndFb)) <<< (DVF - IFB_FRAC);

  assign opI = (ctl.mode == MODE_CCM) ? (vgAl - vfbAl) : vgAl;
  assign opV = (ctl.mode == MODE_CCM) ? (ifbAl - irAl) : (DVW'(0) - irAl);

  // gain products and rescale to state LSB
  logic signed [PIW-1:0] prodI;
  logic signed [PVW-1:0] prodV;
  logic signed [QIW-1:0] deltaI;
  logic signed [QVW-1:0] deltaV;

  assign prodI  = PIW'(opI) * $signed(PIW'({1'b0, DTL_K}));
  assign prodV  = PVW'(opV) * $signed(PVW'({1'b0, DTC_K}));
  assign deltaI = QIW'(prodI >>> SHI);
  assign deltaV = QVW'(prodV >>> SHV);

  // accumulate with one guard bit, then saturate to the state format
  logic signed [SIW-1:0] sumI;
  logic signed [SVW-1:0] sumV;
  logic signed [ILW-1:0] iSat, iNext;
  logic signed [VW-1:0]  vSat;

  assign sumI = SIW'(iReg) + SIW'(deltaI);
  assign sumV = SVW'(vReg) + SVW'(deltaV);

  always_comb begin
    if (sumI > I_HI)      iSat = I_HI[ILW-1:0];
    else if (sumI < I_LO) iSat = I_LO[ILW-1:0];
    else                  iSat = sumI[ILW-1:0];
  end

  always_comb begin
    if (sumV > V_HI)      vSat = V_HI[VW-1:0];
    else if (sumV < V_LO) vSat = V_LO[VW-1:0];
    else                  vSat = sumV[VW-1:0];
  end

  always_comb begin
    unique case (ctl.mode)
      MODE_ON:  iNext = iSat;
      MODE_CCM: iNext = iSat[ILW-1] ? '0 : iSat;
      default:  iNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.loadInit) begin
      vReg <= initVout;
      iReg <= initIl;
    end else if (ctl.update) begin
      vReg <= vSat;
      iReg <= iNext;
    end
  end

  assign vOut       = vReg;
  assign iInd       = iReg;
  assign ilPositive = !iReg[ILW-1] && (iReg != '0);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (ctl.loadInit)
    !ctl.update |=> ($stable(vReg) && $stable(iReg))); // R2

  AST_ON_RISE: assert property (@(posedge clk) disable iff (ctl.loadInit)
    (ctl.update && ctl.mode == MODE_ON && !vIn[VGW-1])
      |=> ($signed(iReg) >= $signed($past(iReg)))); // R3

  AST_CCM_NONNEG: assert property (@(posedge clk) disable iff (ctl.loadInit)
    (ctl.update && ctl.mode == MODE_CCM) |=> !iReg[ILW-1]); // R5

  AST_DCM_ZERO: assert property (@(posedge clk) disable iff (ctl.loadInit)
    (ctl.update && ctl.mode == MODE_DCM) |=> (iReg == '0)); // R6

  AST_DCM_VDROP: assert property (@(posedge clk) disable iff (ctl.loadInit)
    (ctl.update && ctl.mode == MODE_DCM && !iLoad[IRW-1])
      |=> ($signed(vReg) <= $signed($past(vReg)))); // R6

endmodule

// File: rtl/boost_plant.sv
module boost_plant
  import boost_pkg::*;
#(
  parameter int V_INT    = 11,
  parameter int V_FRAC   = 24,
  parameter int I_INT    = 8,
  parameter int I_FRAC   = 17,
  parameter int VG_INT   = 9,
  parameter int VG_FRAC  = 3,
  parameter int IR_INT   = 2,
  parameter int IR_FRAC  = 10,
  parameter int VFB_FRAC = 3,
  parameter int IFB_FRAC = 10,
  parameter int K_W      = 20,
  parameter int K_FRAC   = 24,
  parameter int DTL_CODE = 16777,
  parameter int DTC_CODE = 167772,
  localparam int VW   = 1 + V_INT + V_FRAC,
  localparam int ILW  = 1 + I_INT + I_FRAC,
  localparam int VGW  = 1 + VG_INT + VG_FRAC,
  localparam int IRW  = 1 + IR_INT + IR_FRAC,
  localparam int VFBW = 1 + V_INT + VFB_FRAC,
  localparam int IFBW = 1 + I_INT + IFB_FRAC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stepEn,
  input  logic            gate,
  input  logic [VGW-1:0]  vIn,
  input  logic [IRW-1:0]  iLoad,
  input  logic [VW-1:0]   initVout,
  input  logic [ILW-1:0]  initIl,
  output logic [VW-1:0]   vOut,
  output logic [ILW-1:0]  iInd,
  output logic [VFBW-1:0] vOutFb,
  output logic [IFBW-1:0] iIndFb
);

  step_ctrl_t ctl;
  logic       ilPositive;

  boost_ctrl u_ctrl (
    .rst        (rst),
    .stepEn     (stepEn),
    .gate       (gate),
    .ilPositive (ilPositive),
    .ctl        (ctl)
  );

  boost_dpath #(
    .V_INT    (V_INT),
    .V_FRAC   (V_FRAC),
    .I_INT    (I_INT),
    .I_FRAC   (I_FRAC),
    .VG_INT   (VG_INT),
    .VG_FRAC  (VG_FRAC),
    .IR_INT   (IR_INT),
    .IR_FRAC  (IR_FRAC),
    .VFB_FRAC (VFB_FRAC),
    .IFB_FRAC (IFB_FRAC),
    .K_W      (K_W),
    .K_FRAC   (K_FRAC),
    .DTL_CODE (DTL_CODE),
    .DTC_CODE (DTC_CODE)
  ) u_dpath (
    .clk        (clk),
    .ctl        (ctl),
    .vIn        (vIn),
    .iLoad      (iLoad),
    .initVout   (initVout),
    .initIl     (initIl),
    .vOut       (vOut),
    .iInd       (iInd),
    .vOutFb     (vOutFb),
    .iIndFb     (iIndFb),
    .ilPositive (ilPositive)
  );

endmodule

// File: tb/boost_plant_bench.sv
module boost_plant_bench;

  localparam longint DTL = 16777;
  localparam longint DTC = 167772;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stepEn = 1'b0;
  logic        gate = 1'b0;
  logic [12:0] vIn = '0;
  logic [12:0] iLoad = '0;
  logic [35:0] initVout = '0;
  logic [25:0] initIl = '0;
  logic [35:0] vOut;
  logic [25:0] iInd;
  logic [14:0] vOutFb;
  logic [18:0] iIndFb;

  int checks = 0;
  int failures = 0;
  longint mV = 0;
  longint mI = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  boost_plant u_boost_plant (
    .clk(clk), .rst(rst), .stepEn(stepEn), .gate(gate),
    .vIn(vIn), .iLoad(iLoad), .initVout(initVout), .initIl(initIl),
    .vOut(vOut), .iInd(iInd), .vOutFb(vOutFb), .iIndFb(iIndFb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic longint sat(input longint x, input int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "vOut",   longint'($signed(vOut)),   mV);
    chk(req, "iInd",   longint'($signed(iInd)),   mI);
    chk(req, "vOutFb", longint'($signed(vOutFb)), mV >>> 21);
    chk(req, "iIndFb", longint'($signed(iIndFb)), mI >>> 7);
  endtask

  task automatic modelStep(input bit g, input longint vg, input longint ir);
    longint fbv = mV >>> 21;
    longint fbi = mI >>> 7;
    int mode = g ? 0 : ((mI > 0) ? 1 : 2);
    longint opI = (mode == 1) ? (vg - fbv) : vg;
    longint opV = (mode == 1) ? (fbi - ir) : -ir;
    longint nI = sat(mI + ((DTL * opI) >>> 10), 26);
    if (mode == 1 && nI < 0) nI = 0;
    if (mode == 2) nI = 0;
    mV = sat(mV + ((DTC * opV) >>> 10), 36);
    mI = nI;
  endtask

  task automatic doReset(input longint v0, input longint i0);
    @(negedge clk);
    initVout = 36'(v0);
    initIl   = 26'(i0);
    rst = 1'b1;
    stepEn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    stepEn = 1'b0;
    mV = v0;
    mI = i0;
  endtask

  task automatic doStep(input bit g, input longint vg, input longint ir, input string req);
    @(negedge clk);
    gate = g;
    vIn = 13'(vg);
    iLoad = 13'(ir);
    stepEn = 1'b1;
    modelStep(g, vg, ir);
    @(negedge clk);
    stepEn = 1'b0;
    checkAll(req);
  endtask

  localparam longint V400 = 64'sd400 <<< 24;

  task automatic testReset();
    doReset(V400, 0);
    checkAll("R1");      // reset overrides a simultaneous strobe
    checkAll("R7");
  endtask

  task automatic testHold();
    doReset(V400, 26214);
    @(negedge clk);
    gate = 1'b1; vIn = 13'd1600; iLoad = 13'd768;
    repeat (3) @(negedge clk);
    gate = 1'b0; vIn = 13'd0;
    repeat (2) @(negedge clk);
    checkAll("R2");
  endtask

  task automatic testSwitchOn();
    doReset(V400, 0);
    for (int k = 0; k < 3; k++) doStep(1'b1, 1600, 768, "R3");
  endtask

  task automatic testCcm();
    doReset(V400, 0);
    for (int k = 0; k < 3; k++) doStep(1'b1, 1600, 768, "R3");
    for (int k = 0; k < 4; k++) doStep(1'b0, 1600, 768, "R4");
  endtask

  task automatic testClamp();
    doReset(V400, 13107);   // about 0.1 A
    doStep(1'b0, 0, 768, "R5");
    chk("R5", "iInd zero", longint'($signed(iInd)), 0);
  endtask

  task automatic testDcm();
    doReset(V400, 0);
    doStep(1'b0, 1600, 768, "R6");
    doStep(1'b0, 1600, 768, "R6");
    doReset(V400, -500);    // non-positive current also means DCM
    doStep(1'b0, 1600, 0, "R6");
  endtask

  task automatic testNegFeedback();
    doReset(-1, -1);
    checkAll("R7");
    doReset(-(64'sd3 <<< 21) - 5, -(64'sd7 <<< 7) - 1);
    checkAll("R7");
  endtask

  task automatic testSaturate();
    doReset(V400, (64'sd1 <<< 25) - 100);
    doStep(1'b1, 4095, 0, "R8");
    chk("R8", "iInd max", longint'($signed(iInd)), (64'sd1 <<< 25) - 1);
    doReset(-(64'sd1 <<< 35) + 5, 0);
    doStep(1'b1, 0, 4095, "R8");
    chk("R8", "vOut min", longint'($signed(vOut)), -(64'sd1 <<< 35));
  endtask

  task automatic testBurst();
    doReset(0, 0);
    @(negedge clk);
    gate = 1'b1; vIn = 13'd1600; iLoad = 13'd0;
    stepEn = 1'b1;
    for (int k = 0; k < 3; k++) modelStep(1'b1, 1600, 0);
    repeat (3) @(negedge clk);
    stepEn = 1'b0;
    checkAll("R9");
    for (int k = 0; k < 5; k++) doStep(1'b0, 1600, 10, "R9");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testHold();
    testSwitchOn();
    testCcm();
    testClamp();
    testDcm();
    testNegFeedback();
    testSaturate();
    testBurst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule